// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a larger chip. A host drives a serial clock, an active-low enable and a data line. The block then writes to, or reads from, a bank of 8-bit registers whose contents leave the block on a flat bus that the rest of the chip uses. Each access is one 16-bit frame, shifted most significant bit first. The first byte is the instruction: bit 7 is the command (1 = write, 0 = read) and bits 6..0 are the register address. The second byte is the data.

The address has two fields. Bits 6..4 pick a block and bits 3..0 pick a register inside that block. A mode input selects between two wiring schemes. In four-wire mode (`threeWire` = 0) read data leaves on a dedicated output. In three-wire mode (`threeWire` = 1) the shared data pin turns around during the data byte of a read, and the block raises an output-enable for the pad. Several frames can follow one another while the enable stays low. If the enable rises in the middle of a frame, that frame is dropped.

All serial inputs are brought into the system clock domain through a synchronizer, and the serial-clock edges are detected there. The host clock must therefore be much slower than `clk`.

Top module: `spiRegSlave`

## Requirements
- R1: After reset, the register at address A (A = block*16 + index) holds {1'b0, A} XOR `RST_XOR`. `sdo` and `sdioOe` are 0.
- R2: A frame whose instruction bit 7 is 1 writes its data byte into the addressed register after the 16th rising serial-clock edge. Bits are taken MSB first on rising edges.
- R3: In four-wire mode, a frame whose instruction bit 7 is 0 drives the register's value MSB first on `sdo`. Each bit changes after a falling edge and is valid at rising edges 9 to 16. `sdioOe` stays 0 throughout.
- R4: In three-wire mode, a read drives the same bits on `sdioOut`. `sdioOe` is high from the falling edge after the 8th rising edge until the 16th rising edge, and `sdo` stays 0.
- R5: Writes behave the same in both modes, and `sdioOe` stays 0 during a write.
- R6: Address bits 6..4 select the block and bits 3..0 the register. Blocks at or above `NUM_BLOCKS` are unmapped: reads return 0 and writes change nothing.
- R7: Several frames sent back to back while `spiEnN` stays low each complete as independent accesses.
- R8: A rise of `spiEnN` before the 16th rising edge drops the frame: no register changes, `sdioOe` falls, and the next frame starts counting from bit 0.
- R9: A read leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiClk | input | 1 | Serial clock from the host |
| spiEnN | input | 1 | Active-low frame enable |
| sdioIn | input | 1 | Serial data from the host (pad input side) |
| threeWire | input | 1 | Mode select: 1 = three-wire, 0 = four-wire |
| sdo | output | 1 | Read data in four-wire mode |
| sdioOut | output | 1 | Read data toward the shared pad |
| sdioOe | output | 1 | Output enable for the shared pad |
| cfgOut | output | NUM_BLOCKS*REGS_PER_BLOCK*8 | Register bank; register k at bits k*8 +: 8 |

## Verification
The assertions assume the following about the inputs:
- `threeWire` is held steady while a frame is in progress.
- Each serial-clock level lasts longer than the synchronizer depth plus two system clocks, so that every edge is seen exactly once.

The bench meets these conditions as follows:
- It holds every serial-clock phase for eight system clocks.
- It changes the mode only while the enable is high.
- It moves data only while the serial clock is low.

Read bits are sampled just before each rising edge, where the host would sample them.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 7;
  localparam int BLK_W  = 3;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 8;
  localparam logic CMD_WRITE = 1'b1;

  typedef struct packed {
    logic clear;    // enable high: drop frame state
    logic shiftIn;  // rising edge: take one host bit
    logic capture;  // 8th rising edge: latch address
    logic commit;   // 16th rising edge of a write
    logic loadRd;   // first falling edge of read data byte
    logic shiftRd;  // later falling edges of read data byte
  } spiStrobe_t;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiClk,
  input  logic       spiEnN,
  input  logic       sdioIn,
  input  logic       pendCmd,
  output spiStrobe_t stb,
  output logic       sdiBit,
  output logic       rdActive
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSync, enSync, datSync;
  logic sclkPrev;
  logic [3:0] bitCnt;
  logic isWrite, rdPend;
  logic active, rise, fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      enSync   <= '1;
      datSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], spiClk};
      enSync   <= {enSync[SYNC_STAGES-2:0], spiEnN};
      datSync  <= {datSync[SYNC_STAGES-2:0], sdioIn};
      sclkPrev <= clkSync[LAST];
    end
  end

  assign active = !enSync[LAST];
  assign rise   = active && clkSync[LAST] && !sclkPrev;
  assign fall   = active && !clkSync[LAST] && sclkPrev;
  assign sdiBit = datSync[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      isWrite  <= 1'b0;
      rdPend   <= 1'b0;
      rdActive <= 1'b0;
    end else if (!active) begin
      bitCnt   <= '0;
      isWrite  <= 1'b0;
      rdPend   <= 1'b0;
      rdActive <= 1'b0;
    end else begin
      if (rise) begin
        bitCnt <= bitCnt + 4'd1;
        if (bitCnt == 4'd7) begin
          isWrite <= (pendCmd == CMD_WRITE);
          rdPend  <= (pendCmd != CMD_WRITE);
        end
        if (bitCnt == 4'd15) rdActive <= 1'b0;
      end
      if (fall && rdPend) begin
        rdPend   <= 1'b0;
        rdActive <= 1'b1;
      end
    end
  end

  always_comb begin
    stb         = '0;
    stb.clear   = !active;
    stb.shiftIn = rise;
    stb.capture = rise && (bitCnt == 4'd7);
    stb.commit  = rise && (bitCnt == 4'd15) && isWrite;
    stb.loadRd  = fall && rdPend;
    stb.shiftRd = fall && rdActive;
  end

  // R8: enable high returns the frame to bit zero on the next cycle
  p_abort_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (bitCnt == 4'd0) && !rdActive);
  // R7: frame events never collide, so chained frames stay separate
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.commit, stb.loadRd, stb.shiftRd}));
  // R9: a read frame never produces a commit
  p_no_commit_in_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> !rdActive && !rdPend);
endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import spi_reg_pkg::*;
#(
  parameter int          NUM_BLOCKS     = 6,
  parameter int          REGS_PER_BLOCK = 16,
  parameter logic [7:0]  RST_XOR        = 8'hA5
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiStrobe_t stb,
  input  logic       sdiBit,
  output logic       pendCmd,
  output logic       rdBit,
  output logic [NUM_BLOCKS*REGS_PER_BLOCK*DATA_W-1:0] cfgFlat
);
  localparam int NUM_REGS = NUM_BLOCKS * REGS_PER_BLOCK;
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [6:0]        inShift;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] rdShift;
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] wrData;
  logic [SEL_W-1:0]  sel;
  logic              mapped;

  assign pendCmd = inShift[6];
  assign wrData  = {inShift, sdiBit};
  assign mapped  = (int'(addrReg[ADDR_W-1:IDX_W]) < NUM_BLOCKS) &&
                   (int'(addrReg[IDX_W-1:0]) < REGS_PER_BLOCK);
  assign sel     = SEL_W'(int'(addrReg[ADDR_W-1:IDX_W]) * REGS_PER_BLOCK +
                          int'(addrReg[IDX_W-1:0]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
      addrReg <= '0;
    end else if (stb.clear) begin
      inShift <= '0;
    end else begin
      if (stb.shiftIn) inShift <= {inShift[5:0], sdiBit};
      if (stb.capture) addrReg <= {inShift[5:0], sdiBit};
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] K_ADDR =
      ADDR_W'((k / REGS_PER_BLOCK) * 16 + (k % REGS_PER_BLOCK));
    localparam logic [DATA_W-1:0] K_RST = {1'b0, K_ADDR} ^ RST_XOR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                           regQ[k] <= K_RST;
      else if (stb.commit && mapped && sel == SEL_W'(k))   regQ[k] <= wrData;
    end
    assign cfgFlat[k*DATA_W +: DATA_W] = regQ[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdShift <= '0;
    else if (stb.clear)   rdShift <= '0;
    else if (stb.loadRd)  rdShift <= mapped ? regQ[sel] : '0;
    else if (stb.shiftRd) rdShift <= {rdShift[DATA_W-2:0], 1'b0};
  end

  assign rdBit = rdShift[DATA_W-1];

  // R2: the bank moves only on the cycle after a commit strobe
  p_write_only_on_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgFlat) |-> $past(stb.commit));
  // R6: a read of an unmapped address starts with a zero bit
  p_unmapped_read_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadRd && !mapped) |=> (rdBit == 1'b0));
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spi_reg_pkg::*;
#(
  parameter int         NUM_BLOCKS     = 6,
  parameter int         REGS_PER_BLOCK = 16,
  parameter logic [7:0] RST_XOR        = 8'hA5,
  parameter int         SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiEnN,
  input  logic sdioIn,
  input  logic threeWire,
  output logic sdo,
  output logic sdioOut,
  output logic sdioOe,
  output logic [NUM_BLOCKS*REGS_PER_BLOCK*8-1:0] cfgOut
);
  spiStrobe_t stb;
  logic sdiBit, pendCmd, rdBit, rdActive;

  spiRegCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiEnN(spiEnN),
    .sdioIn(sdioIn), .pendCmd(pendCmd), .stb(stb), .sdiBit(sdiBit),
    .rdActive(rdActive)
  );

  spiRegData #(
    .NUM_BLOCKS(NUM_BLOCKS), .REGS_PER_BLOCK(REGS_PER_BLOCK), .RST_XOR(RST_XOR)
  ) data_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiBit(sdiBit),
    .pendCmd(pendCmd), .rdBit(rdBit), .cfgFlat(cfgOut)
  );

  assign sdioOe  = threeWire && rdActive;
  assign sdioOut = rdBit;
  assign sdo     = !threeWire && rdActive && rdBit;

  // R4: the pad turns around only right after the read data is loaded
  p_oe_turnaround_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdioOe) |-> $past(stb.loadRd) || $past(!threeWire));
  // R5: a write commit never coincides with the pad being driven
  p_write_no_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> !sdioOe);
endmodule

// File: tb/spiRegSlave_tb_top.sv
`timescale 1ns/1ps
module spiRegSlave_tb_top;
  localparam int NB = 6;
  localparam int RPB = 16;
  localparam int NR = NB * RPB;
  localparam logic [7:0] RSTX = 8'hA5;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, spiClk = 1'b0, spiEnN = 1'b1, sdioIn = 1'b0, threeWire = 1'b0;
  logic sdo, sdioOut, sdioOe;
  logic [NR*8-1:0] cfgOut;

  spiRegSlave dut_i (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiEnN(spiEnN), .sdioIn(sdioIn),
    .threeWire(threeWire), .sdo(sdo), .sdioOut(sdioOut), .sdioOe(sdioOe),
    .cfgOut(cfgOut)
  );

  int checks = 0, fails = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [7:0] model [128];

  function automatic bit isMapped(input logic [6:0] a);
    return (int'(a[6:4]) < NB) && (int'(a[3:0]) < RPB);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison of the bank against the model (R2, R6, R9)
  always @(negedge clk) begin
    if (quiet && !done) begin
      int bad;
      bad = -1;
      for (int k = 0; k < NR; k++)
        if (cfgOut[k*8 +: 8] !== model[(k / RPB) * 16 + (k % RPB)] && bad < 0) bad = k;
      checks++;
      if (bad >= 0) begin
        fails++;
        $display("FAIL R2/R9 bank reg %0d: actual %0h expected %0h", bad,
                 cfgOut[bad*8 +: 8], model[(bad / RPB) * 16 + (bad % RPB)]);
      end
    end
  end

  task automatic senLow();
    spiEnN = 1'b0; waitClk(H);
  endtask
  task automatic senHigh();
    spiEnN = 1'b1; waitClk(H);
  endtask

  // one frame; abortAt < 16 stops after that many bits and raises the enable
  task automatic frame(input bit isW, input logic [6:0] a, input logic [7:0] wd,
                       input int abortAt, input string req);
    logic [15:0] word;
    logic [7:0] exp, got;
    bit oeBad, idleBad;
    word = {isW, a, isW ? wd : 8'h00};
    exp = isMapped(a) ? model[a] : 8'h00;
    got = '0; oeBad = 0; idleBad = 0;
    if (isW) quiet = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (i < abortAt) begin
        spiClk = 1'b0; sdioIn = word[15-i]; waitClk(H);
        if (sdioOe !== (threeWire && !isW && i >= 8)) oeBad = 1;
        if (!isW && i >= 8) begin
          got[15-i] = threeWire ? sdioOut : sdo;
          if (threeWire && sdo !== 1'b0) idleBad = 1;
        end
        spiClk = 1'b1; waitClk(H);
      end
    end
    if (abortAt < 16) begin
      spiEnN = 1'b1;
      spiClk = 1'b0; waitClk(H);
      check("R8", sdioOe, 0, "oe after abort");
    end else begin
      spiClk = 1'b0; waitClk(H);
      if (isW && isMapped(a)) model[a] = wd;
      check(isW ? "R5" : "R4", oeBad, 0, "oe window");
      check("R4", sdioOe, 0, "oe released after frame");
      if (!isW) begin
        check(req, got, exp, $sformatf("read data addr %0h", a));
        check("R4", idleBad, 0, "sdo quiet in 3-wire");
      end
    end
    quiet = 1'b1;
  endtask

  initial begin
    for (int a = 0; a < 128; a++) model[a] = {1'b0, 7'(a)} ^ RSTX;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R1 reset state
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < NR; k++)
        if (cfgOut[k*8 +: 8] !== model[(k / RPB) * 16 + (k % RPB)]) bad++;
      check("R1", bad, 0, "registers off reset value");
      check("R1", {sdo, sdioOe}, 0, "outputs idle");
    end
    quiet = 1'b1;

    // R2/R3 four-wire write then read
    senLow(); frame(1, 7'h13, 8'h5C, 16, "R2"); senHigh();
    senLow(); frame(0, 7'h13, 8'h00, 16, "R2"); senHigh();
    senLow(); frame(0, 7'h2F, 8'h00, 16, "R3"); senHigh();

    // R4/R5 three-wire
    threeWire = 1'b1; waitClk(H);
    senLow(); frame(1, 7'h40, 8'hC3, 16, "R5"); senHigh();
    senLow(); frame(0, 7'h40, 8'h00, 16, "R4"); senHigh();
    senLow(); frame(0, 7'h07, 8'h00, 16, "R4"); senHigh();
    threeWire = 1'b0; waitClk(H);

    // R7 chained frames under one enable
    senLow();
    frame(1, 7'h01, 8'h11, 16, "R7");
    frame(1, 7'h5F, 8'h22, 16, "R7");
    frame(0, 7'h01, 8'h00, 16, "R7");
    frame(0, 7'h5F, 8'h00, 16, "R7");
    senHigh();

    // R6 address split and unmapped blocks
    senLow(); frame(1, 7'h35, 8'h9A, 16, "R6"); senHigh();
    check("R6", cfgOut[(3*RPB+5)*8 +: 8], 8'h9A, "block 3 index 5 slot");
    senLow(); frame(1, 7'h65, 8'hFF, 16, "R6"); senHigh();
    senLow(); frame(0, 7'h65, 8'h00, 16, "R6"); senHigh();
    senLow(); frame(0, 7'h7E, 8'h00, 16, "R6"); senHigh();

    // R8 aborted write, then a fresh frame
    senLow(); frame(1, 7'h22, 8'h77, 12, "R8");
    check("R8", cfgOut[(2*RPB+2)*8 +: 8], model[7'h22], "partial write kept out");
    senLow(); frame(1, 7'h22, 8'h3D, 16, "R8"); senHigh();
    senLow(); frame(0, 7'h22, 8'h00, 16, "R8"); senHigh();
    // R8 aborted three-wire read releases the pad
    threeWire = 1'b1; waitClk(H);
    senLow(); frame(0, 7'h13, 8'h00, 11, "R8");
    senLow(); frame(0, 7'h13, 8'h00, 16, "R9"); senHigh();
    threeWire = 1'b0; waitClk(H);

    // R9 reads left the bank untouched
    check("R9", cfgOut[(1*RPB+3)*8 +: 8], 8'h5C, "reg 0x13 after reads");

    waitClk(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule